// File: doc/BRIEF.md
# Multi-Pattern Bit Error Rate Tester

This block pairs a test-pattern generator with a pattern checker for one serial bit stream. The generator emits a pseudorandom sequence of length 2^7-1, 2^11-1 or 2^15-1. It can instead emit a quasi-random signal derived from a 2^20-1 sequence, or a host-loaded word of 1 to 32 bits that repeats. On request it inverts a single outgoing bit, so that a known error reaches the far end.

The checker is self-synchronising. While hunting, it loads its prediction register from the received bits. After enough clean bits it declares sync and runs freely from then on. In that state it counts the received bits and the bit errors in saturating counters. A burst of errors makes it drop sync and hunt again. The host reads the results through a latch pulse. The pulse copies both live counters into holding registers and starts a fresh interval.

The transmit side and the receive side each advance only on their own single-cycle bit strobe. This lets the block sit on any path whose bit clock is slower than the system clock.

Top module: `bert`

## Requirements
- R1: With `pat_sel` = 0 the generator emits the 2^7-1 sequence. Each transmit strobe computes new = s[6] XOR s[5] from a 32-bit shift register `s`, shifts it in at s[0], and registers it onto `tx_bit`. If s[6:0] is all zero, new is 1.
- R2: `pat_sel` = 1 selects the 2^11-1 sequence (new = s[10] XOR s[8], forced to 1 if s[10:0] is zero). `pat_sel` = 2 selects the 2^15-1 sequence (new = s[14] XOR s[13], forced to 1 if s[14:0] is zero).
- R3: `pat_sel` = 3 selects the quasi-random signal. The raw bit is s[19] XOR s[16] (forced to 1 if s[19:0] is zero) and is the value shifted in. The transmitted bit is the raw bit OR (s[13:0] all zero), so no run of zeros on `tx_bit` exceeds 14.
- R4: `pat_sel` = 4 repeats `rep_word`. The length is `rep_len_m1` + 1 bits, from 1 to 32. Bit 0 is sent first. A position index starts at 0, steps on each transmit strobe and wraps to 0 after position `rep_len_m1`.
- R5: The shift register resets to all ones. `tx_bit` changes only on a cycle with `tx_en` high. Values 5 to 7 of `pat_sel` act as 0.
- R6: An `ins_err` pulse inverts exactly one generated bit: the one emitted at the first transmit strobe after the pulse. A request made while no strobe comes waits for the next strobe and then clears.
- R7: The checker predicts each received bit from its own 32-bit history, using the rule of the selected pattern. In repeat mode the prediction is the bit received `rep_len_m1` + 1 strobes earlier. After 32 consecutive receive strobes whose bit matches the prediction, `in_sync` rises at the edge of the 32nd strobe.
- R8: While in sync, the received bits are split into consecutive 64-bit blocks, starting when sync is gained. The sixth mismatch within one block clears `in_sync` at that strobe. While hunting, the history shifts in the received bit; while in sync, it shifts in its own prediction.
- R9: Only strobes received while in sync are counted: every such strobe in a 32-bit bit counter, and every mismatching one in a 24-bit error counter. Both counters saturate at all ones.
- R10: A `cnt_latch` pulse copies both live counters to `err_hold` and `bit_hold`. It then restarts the live counters from the event of that same cycle, so a latch with no receive strobe restarts them from zero.
- R11: After reset, `tx_bit`, `in_sync`, `err_hold` and `bit_hold` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit bit strobe |
| rx_en | input | 1 | Receive bit strobe |
| pat_sel | input | 3 | Pattern select: 0 2^7-1, 1 2^11-1, 2 2^15-1, 3 quasi-random, 4 repeat word |
| rep_word | input | REP_W (32) | Repeating word, bit 0 first |
| rep_len_m1 | input | clog2(REP_W) (5) | Repeat length minus one |
| ins_err | input | 1 | Single-error insert request |
| rx_bit | input | 1 | Received data bit, valid with `rx_en` |
| cnt_latch | input | 1 | Copy counters to holding registers and restart them |
| tx_bit | output | 1 | Generated data bit |
| in_sync | output | 1 | Checker synchronised |
| err_hold | output | ERR_W (24) | Latched error count |
| bit_hold | output | BIT_W (32) | Latched bit count |

## Verification
The assertions take for granted that the strobes and the request and latch inputs are single-cycle pulses. They also take for granted that the pattern selection, the repeat word and its length stay constant between resets, so that generator and checker follow the same rule. The stimulus respects this: it changes the configuration only while reset is held, keeps each strobe to one cycle with idle cycles between strobes, and issues insert and latch pulses only in cycles with no strobe. The receive stream is the transmitted stream looped back one cycle later. It can be inverted on purpose to hold the checker out of sync.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam int SR_W      = 32;
    localparam int ZERO_RUN  = 14;

    typedef enum logic [2:0] {
        PAT_P7   = 3'd0,
        PAT_P11  = 3'd1,
        PAT_P15  = 3'd2,
        PAT_QRSS = 3'd3,
        PAT_REP  = 3'd4
    } pat_e;

    typedef struct packed {
        logic bit_inc;
        logic err_inc;
    } cnt_evt_t;

    function automatic pat_e decode_pat(logic [2:0] code);
        case (code)
            3'd1:    return PAT_P11;
            3'd2:    return PAT_P15;
            3'd3:    return PAT_QRSS;
            3'd4:    return PAT_REP;
            default: return PAT_P7;
        endcase
    endfunction

    // Raw feedback bit of the selected polynomial, with a lock-up guard
    function automatic logic lfsr_next(pat_e p, logic [SR_W-1:0] s);
        case (p)
            PAT_P11:  return (s[10:0] == '0) ? 1'b1 : (s[10] ^ s[8]);
            PAT_P15:  return (s[14:0] == '0) ? 1'b1 : (s[14] ^ s[13]);
            PAT_QRSS: return (s[19:0] == '0) ? 1'b1 : (s[19] ^ s[16]);
            default:  return (s[6:0]  == '0) ? 1'b1 : (s[6]  ^ s[5]);
        endcase
    endfunction

    // Zero-run limiter of the quasi-random signal
    function automatic logic qrss_shape(logic raw, logic [SR_W-1:0] s);
        return raw | (s[ZERO_RUN-1:0] == '0);
    endfunction

endpackage

// File: rtl/bert_gen.sv
module bert_gen
    import bert_pkg::*;
#(
    parameter int REP_W = 32,
    localparam int LEN_W = $clog2(REP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  pat_e             pat,
    input  logic [REP_W-1:0] word,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             ins_req,
    output logic             bit_o
);
    logic [SR_W-1:0]  sr;
    logic [LEN_W-1:0] idx;
    logic             pend;
    logic             raw;
    logic             nxt;

    always_comb begin
        raw = lfsr_next(pat, sr);
        case (pat)
            PAT_REP:  nxt = word[idx];
            PAT_QRSS: nxt = qrss_shape(raw, sr);
            default:  nxt = raw;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '1;
            idx   <= '0;
            pend  <= 1'b0;
            bit_o <= 1'b0;
        end else if (en) begin
            bit_o <= nxt ^ pend;
            pend  <= ins_req;
            if (pat == PAT_REP)
                idx <= (idx >= len_m1) ? '0 : idx + 1'b1;
            else
                sr  <= {sr[SR_W-2:0], raw};
        end else begin
            pend <= pend | ins_req;
        end
    end
endmodule

// File: rtl/bert_rx_track.sv
module bert_rx_track
    import bert_pkg::*;
#(
    parameter int REP_W = 32,
    localparam int LEN_W = $clog2(REP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  pat_e             pat,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             rx_bit,
    input  logic             locked,
    output logic             mismatch
);
    logic [SR_W-1:0] hist;
    logic            raw;
    logic            pred_raw;
    logic            expect_bit;

    always_comb begin
        raw        = lfsr_next(pat, hist);
        pred_raw   = (pat == PAT_REP) ? hist[len_m1] : raw;
        expect_bit = (pat == PAT_QRSS) ? qrss_shape(raw, hist) : pred_raw;
        mismatch   = expect_bit ^ rx_bit;
    end

    // Hunting: self-load from the line; locked: free-run on predictions
    always_ff @(posedge clk) begin
        if (rst)
            hist <= '1;
        else if (en)
            hist <= {hist[SR_W-2:0], locked ? pred_raw : rx_bit};
    end
endmodule

// File: rtl/bert_sync.sv
module bert_sync
    import bert_pkg::*;
#(
    parameter int SYNC_RUN  = 32,
    parameter int BLOCK_LEN = 64,
    parameter int LOSS_ERR  = 6,
    localparam int RUN_W = $clog2(SYNC_RUN),
    localparam int BLK_W = $clog2(BLOCK_LEN),
    localparam int BE_W  = $clog2(LOSS_ERR)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     mismatch,
    output logic     locked,
    output cnt_evt_t evt
);
    typedef enum logic {ST_HUNT, ST_LOCK} sync_e;

    sync_e            st;
    logic [RUN_W-1:0] run;
    logic [BLK_W-1:0] blk;
    logic [BE_W-1:0]  berr;

    assign locked      = (st == ST_LOCK);
    assign evt.bit_inc = en & locked;
    assign evt.err_inc = en & locked & mismatch;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_HUNT;
            run  <= '0;
            blk  <= '0;
            berr <= '0;
        end else if (en) begin
            if (st == ST_HUNT) begin
                if (mismatch) begin
                    run <= '0;
                end else if (run == RUN_W'(SYNC_RUN - 1)) begin
                    st   <= ST_LOCK;
                    run  <= '0;
                    blk  <= '0;
                    berr <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                if (mismatch && berr == BE_W'(LOSS_ERR - 1)) begin
                    st  <= ST_HUNT;
                    run <= '0;
                end else if (blk == BLK_W'(BLOCK_LEN - 1)) begin
                    blk  <= '0;
                    berr <= '0;
                end else begin
                    blk  <= blk + 1'b1;
                    berr <= berr + BE_W'(mismatch);
                end
            end
        end
    end
endmodule

// File: rtl/bert_counters.sv
module bert_counters
    import bert_pkg::*;
#(
    parameter int ERR_W = 24,
    parameter int BIT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_evt_t         evt,
    input  logic             latch,
    output logic [ERR_W-1:0] err_hold,
    output logic [BIT_W-1:0] bit_hold
);
    logic [ERR_W-1:0] live_err;
    logic [BIT_W-1:0] live_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_err <= '0;
            live_bit <= '0;
            err_hold <= '0;
            bit_hold <= '0;
        end else if (latch) begin
            err_hold <= live_err;
            bit_hold <= live_bit;
            live_err <= {{(ERR_W-1){1'b0}}, evt.err_inc};
            live_bit <= {{(BIT_W-1){1'b0}}, evt.bit_inc};
        end else begin
            if (evt.err_inc && live_err != '1)
                live_err <= live_err + 1'b1;
            if (evt.bit_inc && live_bit != '1)
                live_bit <= live_bit + 1'b1;
        end
    end
endmodule

// File: rtl/bert.sv
module bert
    import bert_pkg::*;
#(
    parameter int REP_W     = 32,
    parameter int ERR_W     = 24,
    parameter int BIT_W     = 32,
    parameter int SYNC_RUN  = 32,
    parameter int BLOCK_LEN = 64,
    parameter int LOSS_ERR  = 6,
    localparam int LEN_W = $clog2(REP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [2:0]       pat_sel,
    input  logic [REP_W-1:0] rep_word,
    input  logic [LEN_W-1:0] rep_len_m1,
    input  logic             ins_err,
    input  logic             rx_bit,
    input  logic             cnt_latch,
    output logic             tx_bit,
    output logic             in_sync,
    output logic [ERR_W-1:0] err_hold,
    output logic [BIT_W-1:0] bit_hold
);
    pat_e     pat;
    logic     mismatch;
    cnt_evt_t evt;

    assign pat = decode_pat(pat_sel);

    bert_gen #(.REP_W(REP_W)) gen_i (
        .clk(clk), .rst(rst), .en(tx_en), .pat(pat), .word(rep_word),
        .len_m1(rep_len_m1), .ins_req(ins_err), .bit_o(tx_bit)
    );

    bert_rx_track #(.REP_W(REP_W)) trk_i (
        .clk(clk), .rst(rst), .en(rx_en), .pat(pat), .len_m1(rep_len_m1),
        .rx_bit(rx_bit), .locked(in_sync), .mismatch(mismatch)
    );

    bert_sync #(.SYNC_RUN(SYNC_RUN), .BLOCK_LEN(BLOCK_LEN), .LOSS_ERR(LOSS_ERR)) sync_i (
        .clk(clk), .rst(rst), .en(rx_en), .mismatch(mismatch),
        .locked(in_sync), .evt(evt)
    );

    bert_counters #(.ERR_W(ERR_W), .BIT_W(BIT_W)) cnt_i (
        .clk(clk), .rst(rst), .evt(evt), .latch(cnt_latch),
        .err_hold(err_hold), .bit_hold(bit_hold)
    );
endmodule

// File: rtl/bert_sva.sv
module bert_sva #(
    parameter int ERR_W = 24,
    parameter int BIT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_en,
    input logic             rx_en,
    input logic             cnt_latch,
    input logic             tx_bit,
    input logic             in_sync,
    input logic [ERR_W-1:0] err_hold,
    input logic [BIT_W-1:0] bit_hold
);
    a_r11_reset_state: assert property (@(posedge clk)
        rst |=> (!tx_bit && !in_sync && err_hold == '0 && bit_hold == '0));

    a_r5_tx_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> $stable(tx_bit));

    a_r7_sync_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> $stable(in_sync));

    a_r8_loss_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(in_sync) |-> $past(rx_en));

    a_r10_hold_only_on_latch: assert property (@(posedge clk) disable iff (rst)
        !cnt_latch |=> ($stable(err_hold) && $stable(bit_hold)));

    // R9: every counted error is also a counted bit
    generate
        if (ERR_W <= BIT_W) begin : g_err_le_bits
            a_r9_err_within_bits: assert property (@(posedge clk) disable iff (rst)
                BIT_W'(err_hold) <= bit_hold);
        end
    endgenerate
endmodule

bind bert bert_sva #(.ERR_W(ERR_W), .BIT_W(BIT_W)) sva_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .cnt_latch(cnt_latch),
    .tx_bit(tx_bit), .in_sync(in_sync), .err_hold(err_hold), .bit_hold(bit_hold)
);

// File: tb/bert_tb_top.sv
module bert_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic        rx_en_d = 1'b0;
    logic [2:0]  pat_sel = 3'd0;
    logic [31:0] rep_word = '0;
    logic [4:0]  rep_len_m1 = '0;
    logic        ins_err = 1'b0;
    logic        cnt_latch = 1'b0;
    logic        flip_rx = 1'b0;
    logic        rx_bit;
    logic        tx_bit, in_sync, s_tx_bit, s_in_sync;
    logic [23:0] err_hold;
    logic [31:0] bit_hold;
    logic [3:0]  s_err_hold;
    logic [5:0]  s_bit_hold;

    always #(CLK_P/2) clk = ~clk;

    // Loopback: receive strobe one cycle after transmit strobe
    always_ff @(posedge clk) rx_en_d <= tx_en;
    assign rx_bit = tx_bit ^ flip_rx;

    bert dut_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en_d), .pat_sel(pat_sel),
        .rep_word(rep_word), .rep_len_m1(rep_len_m1), .ins_err(ins_err),
        .rx_bit(rx_bit), .cnt_latch(cnt_latch), .tx_bit(tx_bit),
        .in_sync(in_sync), .err_hold(err_hold), .bit_hold(bit_hold)
    );

    bert #(.ERR_W(4), .BIT_W(6)) sat_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en_d), .pat_sel(pat_sel),
        .rep_word(rep_word), .rep_len_m1(rep_len_m1), .ins_err(ins_err),
        .rx_bit(rx_bit), .cnt_latch(cnt_latch), .tx_bit(s_tx_bit),
        .in_sync(s_in_sync), .err_hold(s_err_hold), .bit_hold(s_bit_hold)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference model of the generator, built from the requirements
    logic [31:0] m_sr;
    int          m_idx;
    logic        m_pend;
    logic        expq[$];
    int          zrun;
    int          zmax;
    logic        got;
    logic        want;

    function automatic logic m_fb(int p, logic [31:0] s);
        case (p)
            1: return (s[10:0] == 0) ? 1'b1 : s[10] ^ s[8];
            2: return (s[14:0] == 0) ? 1'b1 : s[14] ^ s[13];
            3: return (s[19:0] == 0) ? 1'b1 : s[19] ^ s[16];
            default: return (s[6:0] == 0) ? 1'b1 : s[6] ^ s[5];
        endcase
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(int p, logic [31:0] w, logic [4:0] lm1);
        @(negedge clk);
        rst = 1'b1; pat_sel = 3'(p); rep_word = w; rep_len_m1 = lm1;
        flip_rx = 1'b0;
        repeat (3) @(negedge clk);
        m_sr = '1; m_idx = 0; m_pend = 1'b0; zrun = 0; zmax = 0;
        expq.delete();
        rst = 1'b0;
    endtask

    // Driver: one transmit strobe; the expected bit goes to the scoreboard
    task automatic step();
        logic r, b;
        int p;
        @(negedge clk);
        p = int'(pat_sel);
        if (p == 4) begin
            b = rep_word[m_idx];
            m_idx = (m_idx >= int'(rep_len_m1)) ? 0 : m_idx + 1;
        end else begin
            r = m_fb(p, m_sr);
            b = (p == 3) ? (r | (m_sr[13:0] == 0)) : r;
            m_sr = {m_sr[30:0], r};
        end
        b = b ^ m_pend;
        m_pend = 1'b0;
        expq.push_back(b);
        tx_en = 1'b1;
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic insert();
        @(negedge clk);
        ins_err = 1'b1;
        m_pend = 1'b1;
        @(negedge clk);
        ins_err = 1'b0;
    endtask

    task automatic latch();
        @(negedge clk);
        cnt_latch = 1'b1;
        @(negedge clk);
        cnt_latch = 1'b0;
    endtask

    // Monitor: compare each generated bit once it is registered
    always @(posedge clk) begin
        if (tx_en && !rst) begin
            #(CLK_P/4);
            n_chk++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL R1 generator: actual %0b expected none queued", tx_bit);
            end else begin
                want = expq.pop_front();
                got  = tx_bit;
                if (got !== want) begin
                    n_bad++;
                    $display("FAIL R1-R6 tx_bit pat %0d: actual %0b expected %0b",
                             pat_sel, got, want);
                end
            end
            zrun = got ? 0 : zrun + 1;
            if (zrun > zmax) zmax = zrun;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset(0, '0, '0);
        repeat (3) @(negedge clk);
        chk("R11 tx_bit", tx_bit, 0);
        chk("R11 in_sync", in_sync, 0);
        chk("R11 err_hold", err_hold, 0);
        chk("R11 bit_hold", bit_hold, 0);

        // R1 / R7: 2^7-1 sequence, sync after exactly 32 clean bits
        steps(31);
        chk("R7 not yet in sync after 31", in_sync, 0);
        step();
        chk("R7 in sync after 32", in_sync, 1);
        steps(8);
        latch();
        chk("R9 bits counted only in sync", bit_hold, 8);
        chk("R9 no errors clean", err_hold, 0);

        // R6 / R9: three inserted errors, one per request
        for (int k = 0; k < 3; k++) begin
            insert();
            repeat (4) @(negedge clk);
            steps(5);
        end
        latch();
        chk("R6 errors inserted", err_hold, 3);
        chk("R9 bit count interval", bit_hold, 15);
        chk("R8 sync kept with 3 errors", in_sync, 1);
        latch();
        chk("R10 cleared err", err_hold, 0);
        chk("R10 cleared bits", bit_hold, 0);

        // R8: sixth error in a block drops sync, then resync
        do_reset(0, '0, '0);
        steps(32);
        for (int k = 1; k <= 6; k++) begin
            insert();
            step();
            if (k == 5) chk("R8 sync after 5 errors", in_sync, 1);
        end
        chk("R8 sync lost at 6th error", in_sync, 0);
        steps(31);
        chk("R8 hunting before 32 clean", in_sync, 0);
        step();
        chk("R8 resync after 32 clean", in_sync, 1);
        latch();
        chk("R9 errors in sync only", err_hold, 6);
        chk("R9 bits in sync only", bit_hold, 6);

        // R2 / R8: inverted 2^11-1 stream never syncs, clean stream does
        do_reset(1, '0, '0);
        flip_rx = 1'b1;
        steps(100);
        chk("R8 inverted stream no sync", in_sync, 0);
        flip_rx = 1'b0;
        steps(50);
        chk("R2 2^11-1 sync", in_sync, 1);
        latch();
        chk("R9 no errors counted while hunting", err_hold, 0);

        // R2: 2^15-1
        do_reset(2, '0, '0);
        steps(60);
        chk("R2 2^15-1 sync", in_sync, 1);

        // R3: quasi-random, zero runs bounded
        do_reset(3, '0, '0);
        steps(2000);
        chk("R3 quasi-random sync", in_sync, 1);
        chk("R3 longest zero run <= 14", (zmax <= 14) ? 1 : 0, 1);
        latch();
        chk("R3 quasi-random no errors", err_hold, 0);

        // R4: repeat word lengths 4, 1 and 32
        do_reset(4, 32'h0000_000B, 5'd3);
        steps(40);
        chk("R4 repeat len 4 sync", in_sync, 1);
        do_reset(4, 32'h0000_0000, 5'd0);
        steps(40);
        chk("R4 repeat len 1 sync", in_sync, 1);
        do_reset(4, 32'hC0FF_EE15, 5'd31);
        steps(80);
        chk("R4 repeat len 32 sync", in_sync, 1);
        latch();
        chk("R4 repeat len 32 no errors", err_hold, 0);

        // R5: unused select code acts as 2^7-1
        do_reset(6, '0, '0);
        steps(40);
        chk("R5 code 6 as 2^7-1 sync", in_sync, 1);

        // R9 / R10: saturation in the narrow instance
        do_reset(0, '0, '0);
        steps(32);
        latch();
        for (int i = 0; i < 300; i++) begin
            if (i % 16 == 0) insert();
            step();
        end
        latch();
        chk("R9 wide err count", err_hold, 19);
        chk("R9 wide bit count", bit_hold, 300);
        chk("R9 narrow err saturates", s_err_hold, 15);
        chk("R9 narrow bits saturate", s_bit_hold, 63);
        chk("R9 narrow still in sync", s_in_sync, 1);

        repeat (4) @(negedge clk);
        chk("R1 scoreboard drained", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule